// File: doc/BRIEF.md
# Memory field extension controller

This block extends a 12-bit processor's address space to eight 4K-word fields. It keeps a current instruction field, a current data field and a pending instruction field, and it moves the pending value into the instruction field only when a jump or subroutine call executes. That way the jump target is fetched from the new field, and the instructions in between still come from the old one. The same deferred scheme carries a user-mode flag from a buffer flip-flop into the user field flip-flop.

The processor gives the block every I/O-group instruction word together with a valid strobe, a strobe for each executed jump or subroutine call, and a strobe for each interrupt taken. The block answers read instructions by returning a merged accumulator value with a write enable, and it answers the user-interrupt test with a skip. When an interrupt is taken, the block saves the instruction field, the data field and the user field and then clears them. A restore instruction brings them back. The interrupt-inhibit output keeps the processor from taking an interrupt while a field change is still waiting for its jump.

Top module: `mfx_ctrl`

## Requirements
- R1: After synchronous reset, the instruction field, data field, pending field, user field, user buffer, user interrupt, user skip flag and interrupt inhibit are all zero.
- R2: An instruction word 62N1 or 62N3 (octal; N is bits 5:3, function is bits 2:0) loads the data field with N. The new value is visible in the cycle after the strobe.
- R3: An instruction word 62N2 or 62N3 loads only the pending field with N. The instruction field stays the same until a jump strobe, which copies the pending field into it. Interrupt inhibit is high from the cycle after the load until the cycle after that jump.
- R4: The read-data-field word 6214 and the read-instruction-field word 6224 raise ac_we in the same cycle. They return ac_in with bits 5:3 replaced by the data field or the instruction field respectively, and all other bits unchanged.
- R5: The read-save word 6234 raises ac_we and returns ac_in with bits 5:3 replaced by the saved instruction field and bits 2:0 replaced by the saved data field.
- R6: A taken interrupt saves the instruction field, data field and user field. It then clears the instruction field, pending field, data field, user field, user buffer and interrupt inhibit.
- R7: The restore word 6244 puts the saved data field into the data field, the saved instruction field into the pending field and the saved user field into the user buffer. It holds interrupt inhibit high until the next jump.
- R8: The set-user word 6274 sets the user buffer and raises interrupt inhibit. The clear-user word 6264 clears the user buffer. A jump copies the user buffer into the user field.
- R9: The user_trap input sets the user interrupt flip-flop and the word 6204 clears it. The word 6254 drives skip in the same cycle when that flip-flop is set, and it also sets the user skip flag. The word 6204 also clears the user skip flag.
- R10: A taken interrupt overrides a jump or an instruction in the same cycle, and a jump overrides an instruction. Words outside 62xx, and 62xx words with function 0, 5, 6 or 7, have no effect and give ac_we low with ac_out equal to ac_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iot_valid | input | 1 | An I/O-group instruction executes this cycle |
| iot_word | input | 12 | The instruction word |
| jump_exec | input | 1 | A jump or subroutine call executes this cycle |
| int_take | input | 1 | An interrupt is taken this cycle |
| user_trap | input | 1 | Sets the user interrupt flip-flop |
| ac_in | input | 12 | Current accumulator |
| ac_out | output | 12 | Accumulator value to write back |
| ac_we | output | 1 | Write ac_out into the accumulator |
| skip | output | 1 | Skip the next instruction |
| if_cur | output | 3 | Current instruction field |
| df_cur | output | 3 | Current data field |
| uf_cur | output | 1 | Current user field |
| usr_skip_flag | output | 1 | User skip flip-flop |
| int_inhibit | output | 1 | Hold off interrupts |

## Verification
The assertions check properties that must hold on every cycle. The instruction field and user field change only on a jump or an interrupt. A jump or an interrupt always releases the inhibit. An interrupt leaves zero fields. A data-field load lands in the next cycle. Skip and the accumulator write appear only with a valid instruction. Other behaviour depends on earlier history, and only the bench scenarios show it. Those scenarios check that the field set by the change-instruction-field word, not some other value, reaches the instruction field after the jump. They check that saved fields survive until a later read or restore. They check that a second interrupt overwrites the saved copy, and that a user interrupt raised in the same cycle as its test does not cause a skip.

// File: rtl/mfx_pkg.sv
package mfx_pkg;

    localparam int WORD_W = 12;
    localparam int FLD_W  = 3;

    localparam logic [2:0] GRP_OPCODE = 3'o6;
    localparam logic [2:0] GRP_DEVICE = 3'o2;

    typedef logic [FLD_W-1:0] fld_t;

    typedef enum logic [3:0] {
        X_NONE,
        X_CLR_UINT,
        X_RD_DF,
        X_RD_IF,
        X_RD_SAVE,
        X_RESTORE,
        X_SKIP_UINT,
        X_CLR_UB,
        X_SET_UB
    } xop_e;

    typedef struct packed {
        logic hit;
        logic ld_df;
        logic ld_pend;
        xop_e xop;
        fld_t num;
    } cmd_t;

    localparam cmd_t CMD_IDLE = '{hit: 1'b0, ld_df: 1'b0, ld_pend: 1'b0,
                                  xop: X_NONE, num: '0};

    function automatic cmd_t decode_word(input logic [WORD_W-1:0] w);
        cmd_t c;
        c     = CMD_IDLE;
        c.num = w[5:3];
        if (w[11:9] == GRP_OPCODE && w[8:6] == GRP_DEVICE) begin
            unique case (w[2:0])
                3'd1: c.ld_df = 1'b1;
                3'd2: c.ld_pend = 1'b1;
                3'd3: begin
                    c.ld_df   = 1'b1;
                    c.ld_pend = 1'b1;
                end
                3'd4: begin
                    unique case (w[5:3])
                        3'd0: c.xop = X_CLR_UINT;
                        3'd1: c.xop = X_RD_DF;
                        3'd2: c.xop = X_RD_IF;
                        3'd3: c.xop = X_RD_SAVE;
                        3'd4: c.xop = X_RESTORE;
                        3'd5: c.xop = X_SKIP_UINT;
                        3'd6: c.xop = X_CLR_UB;
                        default: c.xop = X_SET_UB;
                    endcase
                end
                default: ;
            endcase
        end
        c.hit = c.ld_df | c.ld_pend | (c.xop != X_NONE);
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] merge_mid(input logic [WORD_W-1:0] ac,
                                                     input fld_t f);
        logic [WORD_W-1:0] r;
        r = ac;
        r[2*FLD_W-1:FLD_W] = f;
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] merge_pair(input logic [WORD_W-1:0] ac,
                                                      input fld_t hi,
                                                      input fld_t lo);
        logic [WORD_W-1:0] r;
        r = ac;
        r[2*FLD_W-1:FLD_W] = hi;
        r[FLD_W-1:0]       = lo;
        return r;
    endfunction

endpackage

// File: rtl/mfx_decode.sv
module mfx_decode
    import mfx_pkg::*;
(
    input  logic              iot_valid,
    input  logic [WORD_W-1:0] iot_word,
    input  logic              jump_exec,
    input  logic              int_take,
    output logic              act_int,
    output logic              act_jmp,
    output cmd_t              cmd
);
    cmd_t raw;

    always_comb begin
        raw     = decode_word(iot_word);
        act_int = int_take;
        act_jmp = jump_exec & ~int_take;
        if (iot_valid && !int_take && !jump_exec && raw.hit)
            cmd = raw;
        else
            cmd = CMD_IDLE;
    end
endmodule

// File: rtl/mfx_field_regs.sv
module mfx_field_regs
    import mfx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic act_int,
    input  logic act_jmp,
    input  cmd_t cmd,
    output fld_t if_q,
    output fld_t df_q,
    output fld_t sif_q,
    output fld_t sdf_q,
    output logic pend_q
);
    fld_t ib_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            if_q   <= '0;
            ib_q   <= '0;
            df_q   <= '0;
            sif_q  <= '0;
            sdf_q  <= '0;
            pend_q <= 1'b0;
        end else if (act_int) begin
            sif_q  <= if_q;
            sdf_q  <= df_q;
            if_q   <= '0;
            ib_q   <= '0;
            df_q   <= '0;
            pend_q <= 1'b0;
        end else if (act_jmp) begin
            if_q   <= ib_q;
            pend_q <= 1'b0;
        end else begin
            if (cmd.ld_df)
                df_q <= cmd.num;
            if (cmd.ld_pend)
                ib_q <= cmd.num;
            if (cmd.xop == X_RESTORE) begin
                ib_q <= sif_q;
                df_q <= sdf_q;
            end
            if (cmd.ld_pend || cmd.xop == X_RESTORE || cmd.xop == X_SET_UB)
                pend_q <= 1'b1;
        end
    end
endmodule

// File: rtl/mfx_user_regs.sv
module mfx_user_regs
    import mfx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic act_int,
    input  logic act_jmp,
    input  logic user_trap,
    input  cmd_t cmd,
    output logic uf_q,
    output logic uint_q,
    output logic usf_q
);
    logic ub_q;
    logic suf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ub_q  <= 1'b0;
            uf_q  <= 1'b0;
            suf_q <= 1'b0;
        end else if (act_int) begin
            suf_q <= uf_q;
            uf_q  <= 1'b0;
            ub_q  <= 1'b0;
        end else if (act_jmp) begin
            uf_q <= ub_q;
        end else begin
            unique case (cmd.xop)
                X_SET_UB:  ub_q <= 1'b1;
                X_CLR_UB:  ub_q <= 1'b0;
                X_RESTORE: ub_q <= suf_q;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            uint_q <= 1'b0;
            usf_q  <= 1'b0;
        end else begin
            if (user_trap)
                uint_q <= 1'b1;
            else if (cmd.xop == X_CLR_UINT)
                uint_q <= 1'b0;
            if (cmd.xop == X_CLR_UINT)
                usf_q <= 1'b0;
            else if (cmd.xop == X_SKIP_UINT && uint_q)
                usf_q <= 1'b1;
        end
    end
endmodule

// File: rtl/mfx_ctrl.sv
module mfx_ctrl
    import mfx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              iot_valid,
    input  logic [WORD_W-1:0] iot_word,
    input  logic              jump_exec,
    input  logic              int_take,
    input  logic              user_trap,
    input  logic [WORD_W-1:0] ac_in,
    output logic [WORD_W-1:0] ac_out,
    output logic              ac_we,
    output logic              skip,
    output logic [FLD_W-1:0]  if_cur,
    output logic [FLD_W-1:0]  df_cur,
    output logic              uf_cur,
    output logic              usr_skip_flag,
    output logic              int_inhibit
);
    logic act_int;
    logic act_jmp;
    cmd_t cmd;
    fld_t if_q, df_q, sif_q, sdf_q;
    logic pend_q, uf_q, uint_q, usf_q;

    mfx_decode u_dec (
        .iot_valid (iot_valid),
        .iot_word  (iot_word),
        .jump_exec (jump_exec),
        .int_take  (int_take),
        .act_int   (act_int),
        .act_jmp   (act_jmp),
        .cmd       (cmd)
    );

    mfx_field_regs u_fld (
        .clk     (clk),
        .rst     (rst),
        .act_int (act_int),
        .act_jmp (act_jmp),
        .cmd     (cmd),
        .if_q    (if_q),
        .df_q    (df_q),
        .sif_q   (sif_q),
        .sdf_q   (sdf_q),
        .pend_q  (pend_q)
    );

    mfx_user_regs u_usr (
        .clk       (clk),
        .rst       (rst),
        .act_int   (act_int),
        .act_jmp   (act_jmp),
        .user_trap (user_trap),
        .cmd       (cmd),
        .uf_q      (uf_q),
        .uint_q    (uint_q),
        .usf_q     (usf_q)
    );

    always_comb begin
        ac_out = ac_in;
        ac_we  = 1'b0;
        unique case (cmd.xop)
            X_RD_DF: begin
                ac_out = merge_mid(ac_in, df_q);
                ac_we  = 1'b1;
            end
            X_RD_IF: begin
                ac_out = merge_mid(ac_in, if_q);
                ac_we  = 1'b1;
            end
            X_RD_SAVE: begin
                ac_out = merge_pair(ac_in, sif_q, sdf_q);
                ac_we  = 1'b1;
            end
            default: ;
        endcase
    end

    assign skip          = (cmd.xop == X_SKIP_UINT) && uint_q;
    assign if_cur        = if_q;
    assign df_cur        = df_q;
    assign uf_cur        = uf_q;
    assign usr_skip_flag = usf_q;
    assign int_inhibit   = pend_q;
endmodule

// File: rtl/mfx_ctrl_chk.sv
module mfx_ctrl_chk
    import mfx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              iot_valid,
    input logic [WORD_W-1:0] iot_word,
    input logic              jump_exec,
    input logic              int_take,
    input logic              ac_we,
    input logic              skip,
    input logic [FLD_W-1:0]  if_cur,
    input logic [FLD_W-1:0]  df_cur,
    input logic              uf_cur,
    input logic              int_inhibit
);
    logic df_load;
    assign df_load = iot_valid && !int_take && !jump_exec &&
                     iot_word[11:6] == {GRP_OPCODE, GRP_DEVICE} &&
                     (iot_word[2:0] == 3'd1 || iot_word[2:0] == 3'd3);

    a_r2_df_load: assert property (@(posedge clk) disable iff (rst)
        df_load |=> df_cur == $past(iot_word[5:3]));

    a_r3_if_only_on_jump: assert property (@(posedge clk) disable iff (rst)
        (!jump_exec && !int_take) |=> $stable(if_cur));

    a_r3_inhibit_release: assert property (@(posedge clk) disable iff (rst)
        (jump_exec || int_take) |=> !int_inhibit);

    a_r6_int_clears: assert property (@(posedge clk) disable iff (rst)
        int_take |=> (if_cur == '0 && df_cur == '0 && !uf_cur));

    a_r8_uf_only_on_jump: assert property (@(posedge clk) disable iff (rst)
        (!jump_exec && !int_take) |=> $stable(uf_cur));

    a_r9_skip_needs_iot: assert property (@(posedge clk) disable iff (rst)
        skip |-> (iot_valid && !int_take && !jump_exec));

    a_r4_we_needs_iot: assert property (@(posedge clk) disable iff (rst)
        ac_we |-> (iot_valid && !int_take && !jump_exec));
endmodule

bind mfx_ctrl mfx_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .iot_valid   (iot_valid),
    .iot_word    (iot_word),
    .jump_exec   (jump_exec),
    .int_take    (int_take),
    .ac_we       (ac_we),
    .skip        (skip),
    .if_cur      (if_cur),
    .df_cur      (df_cur),
    .uf_cur      (uf_cur),
    .int_inhibit (int_inhibit)
);

// File: tb/mfx_ctrl_test.sv
module mfx_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 28;

    typedef struct packed {
        logic [3:0]  req;
        logic        intk, jmp, iotv, trap;
        logic [11:0] code, ac;
        logic        ewe;
        logic [11:0] eac;
        logic        eskp;
        logic [2:0]  eif, edf;
        logic        euf, einh, eusf;
    } vec_t;

    // fields: req, int, jump, iot, trap, word, ac_in | we, ac_out, skip | if, df, uf, inhibit, usf after
    localparam vec_t TBL [NV] = '{
        '{4'd2,  0,0,1,0, 12'o6231, 12'o0000, 0, 12'o0000, 0, 3'd0, 3'd3, 0, 0, 0}, // R2
        '{4'd3,  0,0,1,0, 12'o6252, 12'o0000, 0, 12'o0000, 0, 3'd0, 3'd3, 0, 1, 0}, // R3
        '{4'd4,  0,0,1,0, 12'o6224, 12'o7777, 1, 12'o7707, 0, 3'd0, 3'd3, 0, 1, 0}, // R4
        '{4'd4,  0,0,1,0, 12'o6214, 12'o0000, 1, 12'o0030, 0, 3'd0, 3'd3, 0, 1, 0}, // R4
        '{4'd3,  0,1,0,0, 12'o0000, 12'o0000, 0, 12'o0000, 0, 3'd5, 3'd3, 0, 0, 0}, // R3
        '{4'd2,  0,0,1,0, 12'o6263, 12'o0000, 0, 12'o0000, 0, 3'd5, 3'd6, 0, 1, 0}, // R2
        '{4'd8,  0,0,1,0, 12'o6274, 12'o0000, 0, 12'o0000, 0, 3'd5, 3'd6, 0, 1, 0}, // R8
        '{4'd8,  0,1,0,0, 12'o0000, 12'o0000, 0, 12'o0000, 0, 3'd6, 3'd6, 1, 0, 0}, // R8
        '{4'd6,  1,0,0,0, 12'o0000, 12'o0000, 0, 12'o0000, 0, 3'd0, 3'd0, 0, 0, 0}, // R6
        '{4'd5,  0,0,1,0, 12'o6234, 12'o7700, 1, 12'o7766, 0, 3'd0, 3'd0, 0, 0, 0}, // R5
        '{4'd7,  0,0,1,0, 12'o6244, 12'o0000, 0, 12'o0000, 0, 3'd0, 3'd6, 0, 1, 0}, // R7
        '{4'd7,  0,1,0,0, 12'o0000, 12'o0000, 0, 12'o0000, 0, 3'd6, 3'd6, 1, 0, 0}, // R7
        '{4'd9,  0,0,0,1, 12'o0000, 12'o0000, 0, 12'o0000, 0, 3'd6, 3'd6, 1, 0, 0}, // R9
        '{4'd9,  0,0,1,0, 12'o6254, 12'o0000, 0, 12'o0000, 1, 3'd6, 3'd6, 1, 0, 1}, // R9
        '{4'd9,  0,0,1,0, 12'o6204, 12'o0000, 0, 12'o0000, 0, 3'd6, 3'd6, 1, 0, 0}, // R9
        '{4'd9,  0,0,1,0, 12'o6254, 12'o0000, 0, 12'o0000, 0, 3'd6, 3'd6, 1, 0, 0}, // R9
        '{4'd8,  0,0,1,0, 12'o6264, 12'o0000, 0, 12'o0000, 0, 3'd6, 3'd6, 1, 0, 0}, // R8
        '{4'd8,  0,1,0,0, 12'o0000, 12'o0000, 0, 12'o0000, 0, 3'd6, 3'd6, 0, 0, 0}, // R8
        '{4'd10, 0,0,1,0, 12'o6631, 12'o1234, 0, 12'o1234, 0, 3'd6, 3'd6, 0, 0, 0}, // R10
        '{4'd10, 0,0,1,0, 12'o6275, 12'o0000, 0, 12'o0000, 0, 3'd6, 3'd6, 0, 0, 0}, // R10
        '{4'd10, 1,0,1,0, 12'o6211, 12'o0000, 0, 12'o0000, 0, 3'd0, 3'd0, 0, 0, 0}, // R10
        '{4'd3,  0,0,1,0, 12'o6232, 12'o0000, 0, 12'o0000, 0, 3'd0, 3'd0, 0, 1, 0}, // R3
        '{4'd10, 0,1,1,0, 12'o6271, 12'o0000, 0, 12'o0000, 0, 3'd3, 3'd0, 0, 0, 0}, // R10
        '{4'd9,  0,0,1,1, 12'o6254, 12'o0000, 0, 12'o0000, 0, 3'd3, 3'd0, 0, 0, 0}, // R9
        '{4'd9,  0,0,1,0, 12'o6254, 12'o0000, 0, 12'o0000, 1, 3'd3, 3'd0, 0, 0, 1}, // R9
        '{4'd5,  0,0,1,0, 12'o6234, 12'o0000, 1, 12'o0066, 0, 3'd3, 3'd0, 0, 0, 1}, // R5
        '{4'd7,  0,0,1,0, 12'o6244, 12'o0000, 0, 12'o0000, 0, 3'd3, 3'd6, 0, 1, 1}, // R7
        '{4'd7,  0,1,0,0, 12'o0000, 12'o0000, 0, 12'o0000, 0, 3'd6, 3'd6, 0, 0, 1}  // R7
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        iot_valid = 1'b0;
    logic [11:0] iot_word = '0;
    logic        jump_exec = 1'b0;
    logic        int_take = 1'b0;
    logic        user_trap = 1'b0;
    logic [11:0] ac_in = '0;
    logic [11:0] ac_out;
    logic        ac_we, skip, uf_cur, usr_skip_flag, int_inhibit;
    logic [2:0]  if_cur, df_cur;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mfx_ctrl uut (
        .clk           (clk),
        .rst           (rst),
        .iot_valid     (iot_valid),
        .iot_word      (iot_word),
        .jump_exec     (jump_exec),
        .int_take      (int_take),
        .user_trap     (user_trap),
        .ac_in         (ac_in),
        .ac_out        (ac_out),
        .ac_we         (ac_we),
        .skip          (skip),
        .if_cur        (if_cur),
        .df_cur        (df_cur),
        .uf_cur        (uf_cur),
        .usr_skip_flag (usr_skip_flag),
        .int_inhibit   (int_inhibit)
    );

    task automatic check(input int req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s actual=%o expected=%o", req, what, act, exp);
        end
    endtask

    task automatic check_state(input int req, input string what,
                               input logic [2:0] eif, input logic [2:0] edf,
                               input logic euf, input logic einh, input logic eusf);
        check(req, {what, " state"},
              {7'd0, if_cur, df_cur, uf_cur, int_inhibit, usr_skip_flag},
              {7'd0, eif, edf, euf, einh, eusf});
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: state straight after reset
        check_state(1, "reset", 3'd0, 3'd0, 1'b0, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            int_take  = TBL[i].intk;
            jump_exec = TBL[i].jmp;
            iot_valid = TBL[i].iotv;
            user_trap = TBL[i].trap;
            iot_word  = TBL[i].code;
            ac_in     = TBL[i].ac;
            #1;
            check(int'(TBL[i].req), $sformatf("vec%0d comb", i),
                  {2'd0, TBL[i].ewe == ac_we, ac_out, skip},
                  {2'd0, 1'b1, TBL[i].eac, TBL[i].eskp});
            @(posedge clk);
            #1;
            check_state(int'(TBL[i].req), $sformatf("vec%0d", i),
                        TBL[i].eif, TBL[i].edf, TBL[i].euf, TBL[i].einh, TBL[i].eusf);
        end

        // R1: reset in the middle of a run clears everything, including user interrupt
        @(negedge clk);
        int_take = 0; jump_exec = 0; iot_valid = 0; user_trap = 0; ac_in = '0;
        iot_word = 12'o6232;
        iot_valid = 1'b1;
        @(posedge clk);
        #1;
        check_state(3, "pending before reset", 3'd6, 3'd6, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        iot_valid = 1'b0;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check_state(1, "mid-run reset", 3'd0, 3'd0, 1'b0, 1'b0, 1'b0);
        iot_word  = 12'o6254;
        iot_valid = 1'b1;
        #1;
        check(1, "user interrupt cleared by reset", {15'd0, skip}, 16'd0);
        @(posedge clk);
        #1;
        check_state(1, "skip flag after reset", 3'd0, 3'd0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        iot_valid = 1'b0;
        // R3: a jump with nothing pending loads the reset pending field
        jump_exec = 1'b1;
        @(posedge clk);
        #1;
        check_state(3, "jump after reset", 3'd0, 3'd0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        jump_exec = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule